// File: doc/BRIEF.md
# Single-Slot Packet Timestamp Capture Unit

This block latches the value of a free-running 64-bit system time counter at the moment a packet crosses the wire. It has a transmit channel and a receive channel. Each channel has one capture slot, made of a low and a high holding word, and a control word. The control word carries an enable bit and a sticky valid flag.

A transmit start-of-frame is stamped only if the frame's descriptor requests it. A receive start-of-frame is stamped when the receive channel is enabled with the all-packets type. After a slot is filled it ignores all later events until software reads its high word. Each held stamp therefore belongs to exactly one known packet. Software then pairs that stamp with the packet the block flagged with its per-channel stamped pulse.

Register access uses a simple strobe interface. Read data is combinational from the address. A read strobe on a high holding word releases that slot at the next clock edge.

Top module: `ts_capture`

## Requirements
- R1: After reset, both enables, both valid flags, the receive type field and all four holding words are zero. Both stamped pulses are low.
- R2: The register word indices are fixed: 0 is the transmit control word, 1 and 2 are the transmit low and high words, 3 is the receive control word, and 4 and 5 are the receive low and high words. Indices 6 and 7 read as zero. In both control words, bit 4 is a writable enable and bit 0 is the read-only valid flag. A write to bit 0 has no effect.
- R3: The transmit slot captures a start-of-frame only when three conditions hold: the transmit channel is enabled, bit 4 (value 0x10) of the extended descriptor command is set, and the slot is empty. The captured value is `sys_time_i` as sampled at the clock edge of the strobe. The valid flag and the held value are visible after that edge.
- R4: A transmit start-of-frame whose extended command has bit 4 clear is never stamped.
- R5: The receive slot captures a start-of-frame only when the receive type field (control bits 3:1) equals 3'b100, which is control value 0x18 together with the enable. With any other type value the event is not stamped.
- R6: While a channel's valid flag is set, that channel's events do not change the held value.
- R7: A read strobe on a channel's high word clears that channel's valid flag at the next edge. A read of the low word leaves the flag set.
- R8: A disabled channel ignores events and never sets its valid flag. A stamp it already holds stays readable and can still be released by reading the high word.
- R9: An event that coincides with the releasing read of its own channel's high word is dropped. The slot is empty afterwards.
- R10: Receive control bit 5 always mirrors `clk_is_96m_i` (1 means a 96 MHz time base, 0 means 25 MHz) and cannot be written.
- R11: `tx_stamped_o` and `rx_stamped_o` pulse high for exactly one cycle, in the cycle after the edge at which their channel accepted an event. This is the per-packet "stamp taken" status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_time_i | input | TIME_W (64) | Current system time counter value |
| clk_is_96m_i | input | 1 | Time base indication: 1 = 96 MHz, 0 = 25 MHz |
| tx_sof_i | input | 1 | Transmit start-of-frame strobe |
| tx_ext_cmd_i | input | CMD_W (8) | Extended descriptor command of that frame; bit 4 requests a stamp |
| rx_sof_i | input | 1 | Receive start-of-frame strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (side effect on high words) |
| reg_addr_i | input | ADDR_W (3) | Register word index |
| reg_wdata_i | input | DATA_W (32) | Register write data |
| reg_rdata_o | output | DATA_W (32) | Register read data, combinational from the address |
| tx_stamped_o | output | 1 | One-cycle pulse: transmit frame was stamped |
| rx_stamped_o | output | 1 | One-cycle pulse: received frame was stamped |

## Verification
Register read data follows the address within the same cycle. Everything a strobe changes appears one edge later: the held value, the valid flag, the stamped pulse, and the flag cleared by a high-word read. There are no deeper pipelines. The bench drives every input 1 ns after a rising edge and holds it across the next edge. At 1 ns after that edge, it advances a behavioural model from the inputs that were held and compares both pulses and the read data for the current address. Directed checks then pick each requirement's boundary (same-cycle release and event, disabled slot holding a stamp, non-matching type) using values worked out by hand from the time sampled at the strobe's edge.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;

    localparam int NUM_CH      = 2;
    localparam int CH_TX       = 0;
    localparam int CH_RX       = 1;

    localparam int CTL_VALID_BIT = 0;
    localparam int CTL_EN_BIT    = 4;
    localparam int RX_TYPE_LSB   = 1;
    localparam int RX_TYPE_W     = 3;
    localparam int RX_FREQ_BIT   = 5;
    localparam int TX_REQ_BIT    = 4;

    localparam logic [RX_TYPE_W-1:0] RX_TYPE_ALL = 3'b100;

    typedef enum logic [2:0] {
        REG_TX_CTL = 3'd0,
        REG_TX_LO  = 3'd1,
        REG_TX_HI  = 3'd2,
        REG_RX_CTL = 3'd3,
        REG_RX_LO  = 3'd4,
        REG_RX_HI  = 3'd5
    } reg_idx_e;

    typedef struct packed {
        logic                 tx_en;
        logic                 rx_en;
        logic [RX_TYPE_W-1:0] rx_type;
    } ctl_state_t;

endpackage

// File: rtl/ts_event_qual.sv
module ts_event_qual
    import ts_cap_pkg::*;
#(
    parameter bit IS_RX = 1'b0,
    parameter int CMD_W = 8
) (
    input  logic                 sof_i,
    input  logic [CMD_W-1:0]     cmd_i,
    input  logic [RX_TYPE_W-1:0] rx_type_i,
    output logic                 event_o
);

    // One qualifier, two variants: receive gates on the type field,
    // transmit gates on the per-descriptor request bit.
    generate
        if (IS_RX) begin : g_rx
            logic unused_cmd;
            assign unused_cmd = ^cmd_i;
            assign event_o    = sof_i && (rx_type_i == RX_TYPE_ALL);
        end else begin : g_tx
            logic unused_type;
            logic unused_cmd_rest;
            assign unused_type     = ^rx_type_i;
            assign unused_cmd_rest = ^cmd_i;
            assign event_o         = sof_i && cmd_i[TX_REQ_BIT];
        end
    endgenerate

endmodule

// File: rtl/ts_slot.sv
module ts_slot #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              event_i,
    input  logic              clear_i,
    input  logic [TIME_W-1:0] time_i,
    output logic              valid_o,
    output logic              taken_o,
    output logic [TIME_W-1:0] stamp_o
);

    typedef struct packed {
        logic              valid;
        logic              taken;
        logic [TIME_W-1:0] stamp;
    } slot_t;

    slot_t slot_d, slot_q;
    logic  accept;

    always_comb begin
        slot_d       = slot_q;
        slot_d.taken = 1'b0;
        // release has priority; a coinciding event is dropped
        accept = event_i && arm_i && !slot_q.valid && !clear_i;
        if (clear_i) begin
            slot_d.valid = 1'b0;
        end else if (accept) begin
            slot_d.valid = 1'b1;
            slot_d.taken = 1'b1;
            slot_d.stamp = time_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign valid_o = slot_q.valid;
    assign taken_o = slot_q.taken;
    assign stamp_o = slot_q.stamp;

endmodule

// File: rtl/ts_csr.sv
module ts_csr
    import ts_cap_pkg::*;
#(
    parameter int TIME_W = 64,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_i,
    input  logic                             rd_i,
    input  logic [ADDR_W-1:0]                addr_i,
    input  logic [DATA_W-1:0]                wdata_i,
    input  logic                             freq_i,
    input  logic [NUM_CH-1:0]                valid_i,
    input  logic [NUM_CH-1:0][TIME_W-1:0]    stamp_i,
    output logic [NUM_CH-1:0]                en_o,
    output logic [RX_TYPE_W-1:0]             rx_type_o,
    output logic [NUM_CH-1:0]                clear_o,
    output logic [DATA_W-1:0]                rdata_o
);

    localparam int WORD_W = TIME_W / 2;

    ctl_state_t ctl_d, ctl_q;
    logic       unused_wdata;

    assign unused_wdata = ^wdata_i;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_i) begin
            if (addr_i == ADDR_W'(REG_TX_CTL)) begin
                ctl_d.tx_en = wdata_i[CTL_EN_BIT];
            end
            if (addr_i == ADDR_W'(REG_RX_CTL)) begin
                ctl_d.rx_en   = wdata_i[CTL_EN_BIT];
                ctl_d.rx_type = wdata_i[RX_TYPE_LSB +: RX_TYPE_W];
            end
        end
    end

    always_comb begin
        en_o         = '0;
        en_o[CH_TX]  = ctl_q.tx_en;
        en_o[CH_RX]  = ctl_q.rx_en;
        rx_type_o    = ctl_q.rx_type;
        clear_o         = '0;
        clear_o[CH_TX]  = rd_i && (addr_i == ADDR_W'(REG_TX_HI));
        clear_o[CH_RX]  = rd_i && (addr_i == ADDR_W'(REG_RX_HI));
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_W'(REG_TX_CTL): begin
                rdata_o[CTL_VALID_BIT] = valid_i[CH_TX];
                rdata_o[CTL_EN_BIT]    = ctl_q.tx_en;
            end
            ADDR_W'(REG_TX_LO): rdata_o = DATA_W'(stamp_i[CH_TX][WORD_W-1:0]);
            ADDR_W'(REG_TX_HI): rdata_o = DATA_W'(stamp_i[CH_TX][TIME_W-1:WORD_W]);
            ADDR_W'(REG_RX_CTL): begin
                rdata_o[CTL_VALID_BIT]                  = valid_i[CH_RX];
                rdata_o[RX_TYPE_LSB +: RX_TYPE_W]       = ctl_q.rx_type;
                rdata_o[CTL_EN_BIT]                     = ctl_q.rx_en;
                rdata_o[RX_FREQ_BIT]                    = freq_i;
            end
            ADDR_W'(REG_RX_LO): rdata_o = DATA_W'(stamp_i[CH_RX][WORD_W-1:0]);
            ADDR_W'(REG_RX_HI): rdata_o = DATA_W'(stamp_i[CH_RX][TIME_W-1:WORD_W]);
            default: rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/ts_capture.sv
module ts_capture
    import ts_cap_pkg::*;
#(
    parameter int TIME_W = 64,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int CMD_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] sys_time_i,
    input  logic              clk_is_96m_i,
    input  logic              tx_sof_i,
    input  logic [CMD_W-1:0]  tx_ext_cmd_i,
    input  logic              rx_sof_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              tx_stamped_o,
    output logic              rx_stamped_o
);

    logic [NUM_CH-1:0]             ch_event;
    logic [NUM_CH-1:0]             ch_arm;
    logic [NUM_CH-1:0]             ch_clear;
    logic [NUM_CH-1:0]             ch_valid;
    logic [NUM_CH-1:0]             ch_taken;
    logic [NUM_CH-1:0][TIME_W-1:0] ch_stamp;
    logic [RX_TYPE_W-1:0]          rx_type;

    logic              tx_valid, rx_valid, tx_en, rx_en;
    logic [TIME_W-1:0] tx_stamp, rx_stamp;

    ts_csr #(
        .TIME_W (TIME_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (reg_wr_i),
        .rd_i      (reg_rd_i),
        .addr_i    (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .freq_i    (clk_is_96m_i),
        .valid_i   (ch_valid),
        .stamp_i   (ch_stamp),
        .en_o      (ch_arm),
        .rx_type_o (rx_type),
        .clear_o   (ch_clear),
        .rdata_o   (reg_rdata_o)
    );

    ts_event_qual #(
        .IS_RX (1'b0),
        .CMD_W (CMD_W)
    ) u_tx_qual (
        .sof_i     (tx_sof_i),
        .cmd_i     (tx_ext_cmd_i),
        .rx_type_i (rx_type),
        .event_o   (ch_event[CH_TX])
    );

    ts_event_qual #(
        .IS_RX (1'b1),
        .CMD_W (CMD_W)
    ) u_rx_qual (
        .sof_i     (rx_sof_i),
        .cmd_i     ({CMD_W{1'b0}}),
        .rx_type_i (rx_type),
        .event_o   (ch_event[CH_RX])
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            ts_slot #(
                .TIME_W (TIME_W)
            ) u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .arm_i   (ch_arm[c]),
                .event_i (ch_event[c]),
                .clear_i (ch_clear[c]),
                .time_i  (sys_time_i),
                .valid_o (ch_valid[c]),
                .taken_o (ch_taken[c]),
                .stamp_o (ch_stamp[c])
            );
        end
    endgenerate

    assign tx_valid     = ch_valid[CH_TX];
    assign rx_valid     = ch_valid[CH_RX];
    assign tx_en        = ch_arm[CH_TX];
    assign rx_en        = ch_arm[CH_RX];
    assign tx_stamp     = ch_stamp[CH_TX];
    assign rx_stamp     = ch_stamp[CH_RX];
    assign tx_stamped_o = ch_taken[CH_TX];
    assign rx_stamped_o = ch_taken[CH_RX];

endmodule

// File: rtl/ts_capture_chk.sv
module ts_capture_chk
    import ts_cap_pkg::*;
#(
    parameter int TIME_W = 64,
    parameter int ADDR_W = 3,
    parameter int CMD_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TIME_W-1:0] sys_time_i,
    input logic              tx_sof_i,
    input logic [CMD_W-1:0]  tx_ext_cmd_i,
    input logic              rx_sof_i,
    input logic              reg_rd_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic              tx_stamped_o,
    input logic              rx_stamped_o,
    input logic              tx_valid,
    input logic              rx_valid,
    input logic              tx_en,
    input logic              rx_en,
    input logic [TIME_W-1:0] tx_stamp,
    input logic [TIME_W-1:0] rx_stamp
);

    logic tx_rel, rx_rel;
    assign tx_rel = reg_rd_i && (reg_addr_i == ADDR_W'(REG_TX_HI));
    assign rx_rel = reg_rd_i && (reg_addr_i == ADDR_W'(REG_RX_HI));

    assert_tx_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stamped_o |-> (tx_valid && tx_stamp == $past(sys_time_i)));

    assert_tx_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stamped_o |-> $past(tx_sof_i && tx_ext_cmd_i[TX_REQ_BIT]));

    assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_rel) |=> (tx_valid && $stable(tx_stamp)));

    assert_rx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_rel) |=> (rx_valid && $stable(rx_stamp)));

    assert_tx_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rel |=> (!tx_valid && !tx_stamped_o));

    assert_rx_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rel |=> (!rx_valid && !rx_stamped_o));

    assert_tx_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !tx_valid) |=> !tx_valid);

    assert_rx_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !rx_valid) |=> !rx_valid);

    assert_rx_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stamped_o |-> ($past(rx_sof_i) && rx_valid && rx_stamp == $past(sys_time_i)));

    assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stamped_o |=> !tx_stamped_o);

endmodule

bind ts_capture ts_capture_chk #(
    .TIME_W (TIME_W),
    .ADDR_W (ADDR_W),
    .CMD_W  (CMD_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sys_time_i   (sys_time_i),
    .tx_sof_i     (tx_sof_i),
    .tx_ext_cmd_i (tx_ext_cmd_i),
    .rx_sof_i     (rx_sof_i),
    .reg_rd_i     (reg_rd_i),
    .reg_addr_i   (reg_addr_i),
    .tx_stamped_o (tx_stamped_o),
    .rx_stamped_o (rx_stamped_o),
    .tx_valid     (tx_valid),
    .rx_valid     (rx_valid),
    .tx_en        (tx_en),
    .rx_en        (rx_en),
    .tx_stamp     (tx_stamp),
    .rx_stamp     (rx_stamp)
);

// File: tb/ts_capture_bench.sv
`timescale 1ns/1ps
module ts_capture_bench;

    localparam real CLK_HALF = 5.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] sys_time = 64'h0000_0123_89AB_0000;
    logic        clk96 = 1'b1;
    logic        tx_sof = 1'b0;
    logic [7:0]  tx_cmd = 8'h00;
    logic        rx_sof = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        tx_stamped, rx_stamped;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    bit        m_tx_en, m_rx_en, m_tx_v, m_rx_v, m_tx_p, m_rx_p;
    bit [2:0]  m_rx_type;
    bit [63:0] m_tx_ts, m_rx_ts;

    always #(CLK_HALF) clk = ~clk;

    ts_capture u_ts_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .sys_time_i   (sys_time),
        .clk_is_96m_i (clk96),
        .tx_sof_i     (tx_sof),
        .tx_ext_cmd_i (tx_cmd),
        .rx_sof_i     (rx_sof),
        .reg_wr_i     (reg_wr),
        .reg_rd_i     (reg_rd),
        .reg_addr_i   (reg_addr),
        .reg_wdata_i  (reg_wdata),
        .reg_rdata_o  (reg_rdata),
        .tx_stamped_o (tx_stamped),
        .rx_stamped_o (rx_stamped)
    );

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return {27'd0, m_tx_en, 3'd0, m_tx_v};
            3'd1: return m_tx_ts[31:0];
            3'd2: return m_tx_ts[63:32];
            3'd3: return {26'd0, clk96, m_rx_en, m_rx_type, m_rx_v};
            3'd4: return m_rx_ts[31:0];
            3'd5: return m_rx_ts[63:32];
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_step();
        bit tx_rel, rx_rel, tx_acc, rx_acc;
        tx_rel = reg_rd && reg_addr == 3'd2;
        rx_rel = reg_rd && reg_addr == 3'd5;
        tx_acc = tx_sof && tx_cmd[4] && m_tx_en && !m_tx_v && !tx_rel;
        rx_acc = rx_sof && m_rx_en && m_rx_type == 3'b100 && !m_rx_v && !rx_rel;
        if (tx_rel) m_tx_v = 0;
        else if (tx_acc) begin m_tx_v = 1; m_tx_ts = sys_time; end
        if (rx_rel) m_rx_v = 0;
        else if (rx_acc) begin m_rx_v = 1; m_rx_ts = sys_time; end
        m_tx_p = tx_acc;
        m_rx_p = rx_acc;
        if (reg_wr && reg_addr == 3'd0) m_tx_en = reg_wdata[4];
        if (reg_wr && reg_addr == 3'd3) begin
            m_rx_en   = reg_wdata[4];
            m_rx_type = reg_wdata[3:1];
        end
    endtask

    // one clock: model advances from the inputs held across the edge
    task automatic tick();
        @(posedge clk);
        #1;
        model_step();
        check({63'd0, tx_stamped}, {63'd0, m_tx_p}, {cur_req, " tx pulse"});
        check({63'd0, rx_stamped}, {63'd0, m_rx_p}, {cur_req, " rx pulse"});
        check({32'd0, reg_rdata}, {32'd0, exp_rd(reg_addr)}, {cur_req, " rdata"});
        sys_time = sys_time + 64'd7;
        tx_sof = 0; rx_sof = 0; reg_wr = 0; reg_rd = 0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick();
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_rd = 1; reg_addr = a;
        #1;
        d = reg_rdata;
        tick();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] d;
        logic [63:0] t0, t1, t2;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        cur_req = "R1";
        peek(3'd0, d); check({32'd0, d}, 64'h0, "R1 tx ctl");
        peek(3'd3, d); check({32'd0, d}, 64'h20, "R1 rx ctl");
        peek(3'd1, d); check({32'd0, d}, 64'h0, "R1 tx lo");
        peek(3'd5, d); check({32'd0, d}, 64'h0, "R1 rx hi");
        check({63'd0, tx_stamped}, 64'h0, "R1 tx pulse");
        tick();

        // R10: frequency indication is read-only
        cur_req = "R10";
        clk96 = 0;
        peek(3'd3, d); check({32'd0, d}, 64'h0, "R10 freq low");
        wr(3'd3, 32'h20);
        peek(3'd3, d); check({32'd0, d}, 64'h0, "R10 write ignored");
        clk96 = 1;
        peek(3'd3, d); check({32'd0, d}, 64'h20, "R10 freq high");

        // R2: enable writable, valid read-only
        cur_req = "R2";
        wr(3'd0, 32'h11);
        peek(3'd0, d); check({32'd0, d}, 64'h10, "R2 tx ctl");
        peek(3'd7, d); check({32'd0, d}, 64'h0, "R2 unused index");

        // R4: no request bit
        cur_req = "R4";
        tx_sof = 1; tx_cmd = 8'hEF; tick();
        check({63'd0, tx_stamped}, 64'h0, "R4 no pulse");
        peek(3'd0, d); check({32'd0, d}, 64'h10, "R4 no valid");

        // R3: requested stamp
        cur_req = "R3";
        t0 = sys_time;
        tx_sof = 1; tx_cmd = 8'h10; tick();
        check({63'd0, tx_stamped}, 64'h1, "R11 tx pulse");
        peek(3'd0, d); check({32'd0, d}, 64'h11, "R3 valid");
        peek(3'd1, d); check({32'd0, d}, {32'd0, t0[31:0]}, "R3 lo");
        peek(3'd2, d); check({32'd0, d}, {32'd0, t0[63:32]}, "R3 hi");

        // R6: locked slot
        cur_req = "R6";
        tx_sof = 1; tx_cmd = 8'hFF; tick();
        check({63'd0, tx_stamped}, 64'h0, "R6 no pulse");
        peek(3'd1, d); check({32'd0, d}, {32'd0, t0[31:0]}, "R6 held");

        // R7: low read keeps, high read releases
        cur_req = "R7";
        rd(3'd1, d);
        peek(3'd0, d); check({32'd0, d}, 64'h11, "R7 lo read keeps");
        rd(3'd2, d); check({32'd0, d}, {32'd0, t0[63:32]}, "R7 hi data");
        peek(3'd0, d); check({32'd0, d}, 64'h10, "R7 released");

        // R5: type filter
        cur_req = "R5";
        wr(3'd3, 32'h12);
        rx_sof = 1; tick();
        peek(3'd3, d); check({32'd0, d}, 64'h32, "R5 other type");
        wr(3'd3, 32'h18);
        t1 = sys_time;
        rx_sof = 1; tick();
        check({63'd0, rx_stamped}, 64'h1, "R11 rx pulse");
        tick();
        check({63'd0, rx_stamped}, 64'h0, "R11 single pulse");
        peek(3'd3, d); check({32'd0, d}, 64'h39, "R5 valid");
        peek(3'd4, d); check({32'd0, d}, {32'd0, t1[31:0]}, "R5 lo");

        // R9: event coinciding with release
        cur_req = "R9";
        rx_sof = 1; rd(3'd5, d);
        check({32'd0, d}, {32'd0, t1[63:32]}, "R9 hi data");
        check({63'd0, rx_stamped}, 64'h0, "R9 no pulse");
        peek(3'd3, d); check({32'd0, d}, 64'h38, "R9 slot empty");

        // R8: disabled channel
        cur_req = "R8";
        t2 = sys_time;
        rx_sof = 1; tick();
        wr(3'd3, 32'h08);
        peek(3'd3, d); check({32'd0, d}, 64'h29, "R8 held while disabled");
        rx_sof = 1; tick();
        peek(3'd4, d); check({32'd0, d}, {32'd0, t2[31:0]}, "R8 readable");
        rd(3'd5, d); check({32'd0, d}, {32'd0, t2[63:32]}, "R8 hi");
        rx_sof = 1; tick();
        check({63'd0, rx_stamped}, 64'h0, "R8 no pulse");
        peek(3'd3, d); check({32'd0, d}, 64'h28, "R8 stays empty");
        wr(3'd0, 32'h0);
        tx_sof = 1; tx_cmd = 8'h10; tick();
        peek(3'd0, d); check({32'd0, d}, 64'h0, "R8 tx disabled");

        // mixed stimulus against the model (R3 R5 R6 R7 R9 R11)
        cur_req = "R3 R5 R6 R7 R9 R11 mixed";
        for (int i = 0; i < 600; i++) begin
            tx_sof   = ($urandom % 3) == 0;
            tx_cmd   = 8'($urandom);
            rx_sof   = ($urandom % 3) == 0;
            reg_addr = 3'($urandom);
            reg_rd   = ($urandom % 4) == 0;
            reg_wr   = ($urandom % 16) == 0;
            reg_wdata = (($urandom % 4) != 0) ? 32'h18 : ($urandom & 32'h3F);
            if (($urandom % 32) == 0) clk96 = ~clk96;
            tick();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule